// File: doc/BRIEF.md
# Flag-Setting Add/Subtract Unit

This unit is the arithmetic core of an integer execute stage. From two 64-bit operands it forms a sum or a difference at a selectable 32-bit or 64-bit width. It also keeps a four-bit condition register that holds the negative, zero, carry and overflow flags. All plain and carry-chained add and subtract forms run through one adder. A subtraction feeds the adder the inverted second operand with a carry-in. A carry-chained form takes its carry-in from the stored carry flag.

Two conditional-compare operations let a sequence of comparisons be chained without branches. The caller supplies a condition code, which the unit tests against the stored flags. If the test passes, the flags take the outcome of the compare or compare-negative. If the test fails, the flags are loaded from a caller-supplied four-bit immediate. The result is combinational. The flag register is written at the rising clock edge of a cycle in which `opValid` is high.

Top module: `flag_alu`

## Requirements
- R1: `op` selects the operation: 0 add, 1 subtract, 2 add-with-carry, 3 subtract-with-carry, 4 conditional compare, 5 conditional compare-negative, 6 and 7 reserved. Add gives `result` = opA + opB modulo the selected width.
- R2: Subtract gives opA + ~opB + 1, which is opA − opB modulo the width.
- R3: Add-with-carry gives opA + opB + C. Subtract-with-carry gives opA + ~opB + C. C is the stored carry flag, taken before the clock edge.
- R4: The computed carry is 1 exactly when the unsigned sum of both adder inputs and the carry-in is larger than the largest unsigned value of the selected width.
- R5: The computed overflow is 1 exactly when both adder inputs (the second one after any inversion) have equal sign bits and the sign bit of the result differs from them.
- R6: The computed negative flag is the top bit of the result at the selected width. The computed zero flag is 1 when every result bit at that width is 0.
- R7: For ops 0–3, the flags register loads the computed flags only when `setFlags` is 1. Otherwise it keeps its value.
- R8: For ops 4 and 5, when the condition passes, the flags load the outcome of opA − opB (op 4) or opA + opB (op 5), whatever the value of `setFlags`. `result` shows that difference or sum.
- R9: For ops 4 and 5, when the condition fails, the flags load `immFlags` unchanged.
- R10: The condition codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !(C&!Z), 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 its inverse, 14 and 15 always pass.
- R11: When `is64` is 0, the result and the flags depend only on bits 31:0 of the operands, and `result[63:32]` is 0.
- R12: Reset (`rstN` low) clears the flags. The flags bits are N=3, Z=2, C=1, V=0. They change only at a rising edge where `opValid` is 1.
- R13: Reserved ops 6 and 7 drive `result` to 0 and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | The operation on the inputs executes at the next rising edge |
| op | input | 3 | Operation select (R1) |
| is64 | input | 1 | 1 = 64-bit width, 0 = 32-bit width |
| setFlags | input | 1 | Flag update enable for ops 0–3 |
| condCode | input | 4 | Condition for ops 4 and 5 (R10) |
| immFlags | input | 4 | Flags loaded when the condition fails, bits N,Z,C,V = 3..0 |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| result | output | 64 | Combinational sum or difference at the selected width |
| flags | output | 4 | Stored flags, N,Z,C,V = bits 3..0 |

## Verification
The assertions check the following on every cycle:
- the flags hold when nothing writes them: update disabled, idle, or reserved op;
- the upper result half is zero in 32-bit mode;
- a failing condition copies the immediate;
- the stored N and Z flags agree with the result that was on the port one cycle earlier.

Carry and overflow need the operands of a full reference addition, so only the bench can show them. The same holds for the carry-chained forms and for every one of the sixteen condition codes, which the bench walks against all sixteen flag patterns.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_ADDC = 3'd2,
    OP_SUBC = 3'd3,
    OP_CCMP = 3'd4,
    OP_CCMN = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } aluOp_t;

  typedef enum logic [3:0] {
    CC_ZSET  = 4'd0,
    CC_ZCLR  = 4'd1,
    CC_CSET  = 4'd2,
    CC_CCLR  = 4'd3,
    CC_NSET  = 4'd4,
    CC_NCLR  = 4'd5,
    CC_VSET  = 4'd6,
    CC_VCLR  = 4'd7,
    CC_UGT   = 4'd8,
    CC_ULE   = 4'd9,
    CC_SGE   = 4'd10,
    CC_SLT   = 4'd11,
    CC_SGT   = 4'd12,
    CC_SLE   = 4'd13,
    CC_ALW   = 4'd14,
    CC_ALW2  = 4'd15
  } condCode_t;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cinSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    invertB;
    cinSel_t cinSel;
    logic    resultEn;
    logic    flagWrite;
    logic    flagFromImm;
  } dpStrobes_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

endpackage

// File: rtl/flag_alu_dp.sv
module flag_alu_dp
  import flag_alu_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  dpStrobes_t        strobes,
  input  logic              is64,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              curCarry,
  output logic [DATA_W-1:0] result,
  output nzcv_t             aluFlags
);
  localparam int HI_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0] bEff;
  logic              carryIn;
  logic [NARROW_W:0] lowSum;
  logic [HI_W:0]     hiSum;
  logic [DATA_W-1:0] widthSum;
  logic              signA;
  logic              signB;
  logic              signR;
  logic              lowZero;
  logic              hiZero;

  // operand conditioning
  always_comb begin
    bEff = strobes.invertB ? ~opB : opB;
    unique case (strobes.cinSel)
      CIN_ONE:  carryIn = 1'b1;
      CIN_FLAG: carryIn = curCarry;
      default:  carryIn = 1'b0;
    endcase
  end

  // split adder: the low half's carry ripples into the high half
  always_comb begin
    lowSum = {1'b0, opA[NARROW_W-1:0]} + {1'b0, bEff[NARROW_W-1:0]}
           + {{NARROW_W{1'b0}}, carryIn};
    hiSum  = {1'b0, opA[DATA_W-1:NARROW_W]} + {1'b0, bEff[DATA_W-1:NARROW_W]}
           + {{HI_W{1'b0}}, lowSum[NARROW_W]};
  end

  always_comb begin
    if (is64) widthSum = {hiSum[HI_W-1:0], lowSum[NARROW_W-1:0]};
    else      widthSum = {{HI_W{1'b0}}, lowSum[NARROW_W-1:0]};
  end

  // flag extraction at the selected width
  always_comb begin
    signA   = is64 ? opA[DATA_W-1]  : opA[NARROW_W-1];
    signB   = is64 ? bEff[DATA_W-1] : bEff[NARROW_W-1];
    signR   = is64 ? hiSum[HI_W-1]  : lowSum[NARROW_W-1];
    lowZero = ~|lowSum[NARROW_W-1:0];
    hiZero  = ~|hiSum[HI_W-1:0];

    aluFlags.n = signR;
    aluFlags.z = lowZero & (hiZero | ~is64);
    aluFlags.c = is64 ? hiSum[HI_W] : lowSum[NARROW_W];
    aluFlags.v = (signA == signB) && (signR != signA);
  end

  assign result = strobes.resultEn ? widthSum : '0;

endmodule

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
(
  input  logic       opValid,
  input  aluOp_t     op,
  input  logic       setFlags,
  input  condCode_t  condCode,
  input  nzcv_t      curFlags,
  output dpStrobes_t strobes
);
  logic condPass;
  logic isArith;
  logic isCond;

  // condition evaluation against the stored flags
  always_comb begin
    unique case (condCode)
      CC_ZSET: condPass = curFlags.z;
      CC_ZCLR: condPass = ~curFlags.z;
      CC_CSET: condPass = curFlags.c;
      CC_CCLR: condPass = ~curFlags.c;
      CC_NSET: condPass = curFlags.n;
      CC_NCLR: condPass = ~curFlags.n;
      CC_VSET: condPass = curFlags.v;
      CC_VCLR: condPass = ~curFlags.v;
      CC_UGT:  condPass = curFlags.c & ~curFlags.z;
      CC_ULE:  condPass = ~curFlags.c | curFlags.z;
      CC_SGE:  condPass = (curFlags.n == curFlags.v);
      CC_SLT:  condPass = (curFlags.n != curFlags.v);
      CC_SGT:  condPass = ~curFlags.z & (curFlags.n == curFlags.v);
      CC_SLE:  condPass = curFlags.z | (curFlags.n != curFlags.v);
      default: condPass = 1'b1;
    endcase
  end

  always_comb begin
    isArith = 1'b0;
    isCond  = 1'b0;
    strobes = '{invertB: 1'b0, cinSel: CIN_ZERO, resultEn: 1'b1,
                flagWrite: 1'b0, flagFromImm: 1'b0};
    unique case (op)
      OP_ADD:  begin isArith = 1'b1; end
      OP_SUB:  begin isArith = 1'b1; strobes.invertB = 1'b1; strobes.cinSel = CIN_ONE; end
      OP_ADDC: begin isArith = 1'b1; strobes.cinSel = CIN_FLAG; end
      OP_SUBC: begin isArith = 1'b1; strobes.invertB = 1'b1; strobes.cinSel = CIN_FLAG; end
      OP_CCMP: begin isCond = 1'b1; strobes.invertB = 1'b1; strobes.cinSel = CIN_ONE; end
      OP_CCMN: begin isCond = 1'b1; end
      default: begin strobes.resultEn = 1'b0; end
    endcase
    strobes.flagWrite   = opValid & ((isArith & setFlags) | isCond);
    strobes.flagFromImm = isCond & ~condPass;
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        op,
  input  logic              is64,
  input  logic              setFlags,
  input  logic [3:0]        condCode,
  input  logic [3:0]        immFlags,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flags
);
  dpStrobes_t strobes;
  nzcv_t      flagReg;
  nzcv_t      aluFlags;

  flag_alu_ctrl u_ctrl (
    .opValid  (opValid),
    .op       (aluOp_t'(op)),
    .setFlags (setFlags),
    .condCode (condCode_t'(condCode)),
    .curFlags (flagReg),
    .strobes  (strobes)
  );

  flag_alu_dp #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_dp (
    .strobes  (strobes),
    .is64     (is64),
    .opA      (opA),
    .opB      (opB),
    .curCarry (flagReg.c),
    .result   (result),
    .aluFlags (aluFlags)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagReg <= '0;
    end else if (strobes.flagWrite) begin
      flagReg <= strobes.flagFromImm ? nzcv_t'(immFlags) : aluFlags;
    end
  end

  assign flags = flagReg;

endmodule

// File: rtl/flag_alu_checker.sv
module flag_alu_checker #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [2:0]        op,
  input logic              is64,
  input logic              setFlags,
  input logic [3:0]        condCode,
  input logic [3:0]        immFlags,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [DATA_W-1:0] result,
  input logic [3:0]        flags
);
  AST_ARITH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && op <= 3'd3 && !setFlags) |=> $stable(flags)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(flags)); // R12

  AST_RSV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && op >= 3'd6) |=> $stable(flags)); // R13

  AST_RSV_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (op >= 3'd6) |-> (result == '0)); // R13

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !is64 |-> (result[DATA_W-1:NARROW_W] == '0)); // R11

  AST_FAIL_IMM: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (op == 3'd4 || op == 3'd5) && condCode == 4'd0 && !flags[2])
    |=> (flags == $past(immFlags))); // R9

  AST_Z_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && op <= 3'd3 && setFlags) |=> (flags[2] == ($past(result) == '0))); // R6

  AST_N_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && op <= 3'd3 && setFlags)
    |=> (flags[3] == ($past(is64) ? $past(result[DATA_W-1]) : $past(result[NARROW_W-1])))); // R6

  AST_ALW_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && op == 3'd5 && condCode == 4'd14) |=> (flags[2] == ($past(result) == '0))); // R8

endmodule

bind flag_alu flag_alu_checker #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (.*);

// File: tb/sim_flag_alu.sv
`timescale 1ns/1ps
module sim_flag_alu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  op = '0;
  logic        is64 = 1'b0;
  logic        setFlags = 1'b0;
  logic [3:0]  condCode = '0;
  logic [3:0]  immFlags = '0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [63:0] result;
  logic [3:0]  flags;

  int   nTests = 0;
  int   nFail = 0;
  logic [3:0] mFlags = 4'h0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  flag_alu u0 (.clk(clk), .rstN(rstN), .opValid(opValid), .op(op), .is64(is64),
               .setFlags(setFlags), .condCode(condCode), .immFlags(immFlags),
               .opA(opA), .opB(opB), .result(result), .flags(flags));

  // reference: {result[63:0], n, z, c, v}
  function automatic logic [67:0] refCalc(input logic [2:0] o, input logic w64,
                                          input logic [63:0] a, input logic [63:0] b,
                                          input logic cFlag);
    logic [63:0] bx;
    logic        cin;
    logic [64:0] s;
    logic [63:0] r;
    logic        n, z, c, v, sa, sb;
    bx = (o == 3'd1 || o == 3'd3 || o == 3'd4) ? ~b : b;
    case (o)
      3'd1, 3'd4: cin = 1'b1;
      3'd2, 3'd3: cin = cFlag;
      default:    cin = 1'b0;
    endcase
    if (w64) begin
      s = {1'b0, a} + {1'b0, bx} + 65'(cin);
      r = s[63:0]; c = s[64]; n = r[63]; sa = a[63]; sb = bx[63];
    end else begin
      s = {33'b0, a[31:0]} + {33'b0, bx[31:0]} + 65'(cin);
      r = {32'b0, s[31:0]}; c = s[32]; n = r[31]; sa = a[31]; sb = bx[31];
    end
    z = (r == 64'd0);
    v = (sa == sb) && (n != sa);
    if (o >= 3'd6) r = '0;
    return {r, n, z, c, v};
  endfunction

  // R10 condition table
  function automatic logic condOk(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v, b;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    case (cc[3:1])
      3'd0: b = z;
      3'd1: b = c;
      3'd2: b = n;
      3'd3: b = v;
      3'd4: b = c && !z;
      3'd5: b = (n == v);
      3'd6: b = !z && (n == v);
      default: b = 1'b1;
    endcase
    if (cc[0] && cc[3:1] != 3'd7) b = !b;
    return b;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic [2:0] o, input logic w64, input logic [63:0] a,
                      input logic [63:0] b, input logic sf, input logic [3:0] cc,
                      input logic [3:0] imm, input string tag);
    logic [67:0] e;
    @(negedge clk);
    op = o; is64 = w64; opA = a; opB = b; setFlags = sf;
    condCode = cc; immFlags = imm; opValid = 1'b1;
    #1;
    e = refCalc(o, w64, a, b, mFlags[1]);
    check({tag, " result"}, result, e[67:4]);
    if (o <= 3'd3 && sf) mFlags = e[3:0];
    else if (o == 3'd4 || o == 3'd5) mFlags = condOk(cc, mFlags) ? e[3:0] : imm;
    @(posedge clk);
    #2;
    opValid = 1'b0;
    check({tag, " flags"}, {60'd0, flags}, {60'd0, mFlags});
  endtask

  function automatic logic [63:0] pickVal();
    case ($urandom % 6)
      0: return 64'd0;
      1: return '1;
      2: return 64'h8000_0000_0000_0000;
      3: return {$urandom, 32'h8000_0000 ^ $urandom};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4021));
    repeat (3) @(negedge clk);
    check("R12 reset flags", {60'd0, flags}, 64'd0);
    rstN = 1'b1;

    // R1 plain add, no carry or overflow
    doOp(3'd0, 1'b1, 64'd5, 64'd7, 1'b1, 4'd0, 4'd0, "R1 add");
    // R4 unsigned wrap sets carry and zero
    doOp(3'd0, 1'b1, '1, 64'd1, 1'b1, 4'd0, 4'd0, "R4 carry64");
    // R5 signed overflow
    doOp(3'd0, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b1, 4'd0, 4'd0, "R5 ovf64");
    // R2 equal subtraction: Z and C set
    doOp(3'd1, 1'b1, 64'd5, 64'd5, 1'b1, 4'd0, 4'd0, "R2 sub");
    // R3 carry-in from stored C (currently 1)
    doOp(3'd2, 1'b1, 64'd1, 64'd1, 1'b1, 4'd0, 4'd0, "R3 adc");
    doOp(3'd3, 1'b0, 64'd10, 64'd3, 1'b1, 4'd0, 4'd0, "R3 sbc");
    // R7 update disabled keeps flags
    doOp(3'd0, 1'b1, '1, '1, 1'b0, 4'd0, 4'd0, "R7 hold");
    // R11 32-bit ignores upper bits
    doOp(3'd0, 1'b0, 64'hDEAD_BEEF_FFFF_FFFF, 64'h1234_5678_0000_0001, 1'b1, 4'd0, 4'd0, "R11 w32");
    doOp(3'd0, 1'b0, 64'hFFFF_FFFF_7FFF_FFFF, 64'd1, 1'b1, 4'd0, 4'd0, "R11 R5 ovf32");
    // R9 failing condition loads immediate (Z is 0 now)
    doOp(3'd1, 1'b1, 64'd9, 64'd2, 1'b1, 4'd0, 4'd0, "R2 clearZ");
    doOp(3'd4, 1'b1, 64'd3, 64'd3, 1'b0, 4'd0, 4'b1010, "R9 immload");
    // R8 always-pass compare-negative
    doOp(3'd5, 1'b1, 64'd4, '1, 1'b0, 4'd14, 4'b1111, "R8 ccmn");
    // R13 reserved ops
    doOp(3'd6, 1'b1, 64'd4, 64'd4, 1'b1, 4'd14, 4'b0101, "R13 rsv6");
    doOp(3'd7, 1'b0, 64'd4, 64'd4, 1'b1, 4'd14, 4'b0101, "R13 rsv7");

    // R10 every condition code against every flag pattern
    for (int f = 0; f < 16; f++) begin
      for (int cc = 0; cc < 16; cc++) begin
        doOp(3'd4, 1'b1, 64'd0, 64'd0, 1'b0, mFlags[2] ? 4'd1 : 4'd0, 4'(f), "R9 preload");
        doOp(3'd4, 1'b1, 64'd0, 64'd0, 1'b0, 4'(cc), 4'b1001, "R10 R8 cond");
      end
    end

    // random mix: R1 R2 R3 R4 R5 R6 R8 R9 R11 R13
    for (int i = 0; i < 600; i++) begin
      doOp(3'($urandom % 8), 1'($urandom), pickVal(), pickVal(), 1'($urandom),
           4'($urandom), 4'($urandom), "R4 R5 R6 random");
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule